// File: doc/BRIEF.md
# Bit-Field and Bit-Count Unit

This block is a 32-bit bit-manipulation unit. A single request selects one of five operations: pulling a field out of a word with zero or sign fill, merging the low bits of a word into a field of an older word, counting leading zeros, and counting set bits. Extract and insert locate the field with a start position and a length. Insert also takes the previous destination value, so that every bit outside the field survives the merge.

A request is presented with a valid strobe. The result and its own valid strobe appear on the next clock. A field that would run past the top of the word is cut off at bit 31 instead of raising an error. The unit accepts a new request on every cycle, so it can be fed back-to-back as one execution slot of a datapath.

Top module: `bfu_top`

## Requirements
- R1: The operation code `opSel` selects the function: 0 is zero-fill extract, 1 is sign-fill extract, 2 is insert, 3 is leading-zero count and 4 is population count. Codes 5, 6 and 7 produce a result of 0.
- R2: Zero-fill extract returns bits `fieldPos` through `fieldPos+fieldLen-1` of `srcVal` in the low bits of the result, with every higher bit 0.
- R3: Sign-fill extract returns the same field as R2, with every bit above the field set equal to the field's most significant bit.
- R4: Insert returns `dstVal` with bits `fieldPos` through `fieldPos+fieldLen-1` replaced by bits 0 through `fieldLen-1` of `srcVal`. Every other bit of `dstVal` is kept.
- R5: A `fieldLen` of 0 makes both extracts return 0, and makes insert return `dstVal` unchanged.
- R6: When `fieldPos+fieldLen` exceeds 32, including any `fieldLen` above 32, the field ends at bit 31. Sign-fill extract then takes its sign from bit 31 of `srcVal`.
- R7: The leading-zero count gives the number of zero bits above the highest set bit of `srcVal`, in the range 0 to 32. An all-zero input gives 32.
- R8: The population count gives the number of set bits of `srcVal`, in the range 0 to 32.
- R9: `resValid` is high in the cycle after `reqValid` is sampled high, and low in the cycle after `reqValid` is sampled low. `result` carries that request's value in the same cycle.
- R10: After reset `resValid` and `result` are 0. A cycle without a request leaves `result` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (see R1) |
| srcVal | input | 32 | Source operand |
| dstVal | input | 32 | Previous destination value, used by insert |
| fieldPos | input | 5 | Lowest bit of the field |
| fieldLen | input | 6 | Field length, 0 to 63 |
| resValid | output | 1 | Result strobe |
| result | output | 32 | Registered result |

## Verification
Two events can share a clock edge: the result of one request is presented while the next request is captured, and the two requests can use different operations. The bench provokes this with long streams of back-to-back requests that mix all eight operation codes. It also inserts idle gaps, and during those gaps it drives junk on the operands. A scoreboard queue matches every presented result to its own request in order. On idle cycles the bench checks that `resValid` follows the previous cycle's strobe and that `result` holds its last value.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    OP_EXTZ = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_CLZ  = 3'd3,
    OP_POP  = 3'd4
  } bfuOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selExt;
    logic signFill;
    logic selIns;
    logic selClz;
    logic selPop;
  } bfuStb_t;

endpackage

// File: rtl/bfu_field.sv
module bfu_field #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned POS_W = $clog2(WIDTH),
  localparam int unsigned LEN_W = POS_W + 1
) (
  input  logic [WIDTH-1:0] srcIn,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [POS_W-1:0] posIn,
  input  logic [LEN_W-1:0] lenIn,
  output logic [WIDTH-1:0] extZero,
  output logic [WIDTH-1:0] extSign,
  output logic [WIDTH-1:0] insOut
);

  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] effLen;
  logic [WIDTH-1:0] lowMask;
  logic [WIDTH-1:0] placeMask;
  logic [WIDTH-1:0] shifted;
  logic [POS_W-1:0] topIdx;
  logic             signBit;

  // bits left between the start position and the top of the word
  assign room   = LEN_W'(WIDTH) - {1'b0, posIn};
  assign effLen = (lenIn > room) ? room : lenIn;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_mask
      assign lowMask[k] = (effLen > LEN_W'(k));
    end
  endgenerate

  assign shifted   = srcIn >> posIn;
  assign placeMask = lowMask << posIn;
  assign topIdx    = POS_W'(effLen - LEN_W'(1));
  assign signBit   = (effLen != '0) && shifted[topIdx];

  assign extZero = shifted & lowMask;
  assign extSign = extZero | (signBit ? ~lowMask : '0);
  assign insOut  = (dstIn & ~placeMask) | ((srcIn & lowMask) << posIn);

endmodule

// File: rtl/bfu_count.sv
module bfu_count #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] valIn,
  output logic [CNT_W-1:0] lzCount,
  output logic [CNT_W-1:0] onesCount
);

  always_comb begin
    logic seen;
    seen    = 1'b0;
    lzCount = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (valIn[i]) begin
        seen = 1'b1;
      end else if (!seen) begin
        lzCount = lzCount + CNT_W'(1);
      end
    end
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < WIDTH; i++) begin
      onesCount = onesCount + CNT_W'(valIn[i]);
    end
  end

endmodule

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    opSel,
  output bfuStb_t       stb,
  output logic          resValid
);

  always_comb begin
    stb          = '0;
    stb.load     = reqValid;
    stb.selExt   = (opSel == OP_EXTZ) || (opSel == OP_EXTS);
    stb.signFill = (opSel == OP_EXTS);
    stb.selIns   = (opSel == OP_INS);
    stb.selClz   = (opSel == OP_CLZ);
    stb.selPop   = (opSel == OP_POP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned POS_W = $clog2(WIDTH),
  localparam int unsigned LEN_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfuStb_t          stb,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [POS_W-1:0] posIn,
  input  logic [LEN_W-1:0] lenIn,
  output logic [WIDTH-1:0] resultQ
);

  logic [WIDTH-1:0] extZero;
  logic [WIDTH-1:0] extSign;
  logic [WIDTH-1:0] insOut;
  logic [LEN_W-1:0] lzCount;
  logic [LEN_W-1:0] onesCount;
  logic [WIDTH-1:0] resultD;

  bfu_field #(.WIDTH(WIDTH)) uField (
    .srcIn   (srcIn),
    .dstIn   (dstIn),
    .posIn   (posIn),
    .lenIn   (lenIn),
    .extZero (extZero),
    .extSign (extSign),
    .insOut  (insOut)
  );

  bfu_count #(.WIDTH(WIDTH)) uCount (
    .valIn     (srcIn),
    .lzCount   (lzCount),
    .onesCount (onesCount)
  );

  always_comb begin
    if (stb.selExt)      resultD = stb.signFill ? extSign : extZero;
    else if (stb.selIns) resultD = insOut;
    else if (stb.selClz) resultD = WIDTH'(lzCount);
    else if (stb.selPop) resultD = WIDTH'(onesCount);
    else                 resultD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         resultQ <= '0;
    else if (stb.load) resultQ <= resultD;
  end

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(resultQ));

  // R8
  pop_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.selPop) |=> (resultQ <= WIDTH));

  // R7
  clz_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.selClz) |=> (resultQ <= WIDTH));

  // R5
  empty_extract_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.selExt && lenIn == '0) |=> (resultQ == '0));

  // R5
  empty_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.selIns && lenIn == '0) |=> (resultQ == $past(dstIn)));

endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  opSel,
  input  logic [31:0] srcVal,
  input  logic [31:0] dstVal,
  input  logic [4:0]  fieldPos,
  input  logic [5:0]  fieldLen,
  output logic        resValid,
  output logic [31:0] result
);

  bfuStb_t stb;

  bfu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opSel    (opSel),
    .stb      (stb),
    .resValid (resValid)
  );

  bfu_datapath #(.WIDTH(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .srcIn   (srcVal),
    .dstIn   (dstVal),
    .posIn   (fieldPos),
    .lenIn   (fieldLen),
    .resultQ (result)
  );

endmodule

// File: tb/bfu_top_test.sv
module bfu_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] dstVal = '0;
  logic [4:0]  fieldPos = '0;
  logic [5:0]  fieldLen = '0;
  logic        resValid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastResult = '0;
  logic        expectOut = 1'b0;
  logic        running = 1'b0;

  bfu_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opSel(opSel),
    .srcVal(srcVal), .dstVal(dstVal), .fieldPos(fieldPos),
    .fieldLen(fieldLen), .resValid(resValid), .result(result)
  );

  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // reference model written bit by bit from the requirements
  function automatic logic [31:0] model(input int op, input logic [31:0] s,
      input logic [31:0] d, input int pos, input int len);
    logic [31:0] r;
    int eff;
    logic seen;
    eff = len;
    if (pos + len > 32) eff = 32 - pos;
    r = '0;
    case (op)
      0, 1: begin
        for (int k = 0; k < eff; k++) r[k] = s[pos + k];
        if (op == 1 && eff > 0 && r[eff - 1])
          for (int k = eff; k < 32; k++) r[k] = 1'b1;
      end
      2: begin
        r = d;
        for (int k = 0; k < eff; k++) r[pos + k] = s[k];
      end
      3: begin
        seen = 1'b0;
        for (int k = 31; k >= 0; k--) begin
          if (s[k]) seen = 1'b1;
          else if (!seen) r = r + 1;
        end
      end
      4: for (int k = 0; k < 32; k++) r = r + 32'(s[k]);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic issue(input int op, input logic [31:0] s, input logic [31:0] d,
                       input int pos, input int len, input string req);
    @(negedge clk);
    reqValid = 1'b1;
    opSel    = 3'(op);
    srcVal   = s;
    dstVal   = d;
    fieldPos = 5'(pos);
    fieldLen = 6'(len);
    expQ.push_back(model(op, s, d, pos, len));
    tagQ.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      opSel    = 3'($urandom);
      srcVal   = $urandom;
      dstVal   = $urandom;
      fieldPos = 5'($urandom);
      fieldLen = 6'($urandom);
    end
  endtask

  function automatic string reqFor(input int op, input int pos, input int len);
    if (len == 0 && op <= 2) return "R5";
    if (pos + len > 32 && op <= 2) return "R6";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R7";
      4: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) expectOut <= rstN && reqValid;

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      check(resValid == expectOut, "R9 valid", 32'(resValid), 32'(expectOut));
      if (resValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected result", result, 32'hx);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(result == e, t, result, e);
        end
      end else begin
        check(result == lastResult, "R10 hold", result, lastResult);
      end
      lastResult = result;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R10 reset valid", 32'(resValid), 0);
    check(result == '0, "R10 reset result", result, 0);
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);

    // R2 plain extract
    issue(0, 32'hDEADBEEF, 0, 4, 8, "R2");
    issue(0, 32'hFFFFFFFF, 0, 0, 32, "R2");
    // R3 sign fill, negative and positive fields
    issue(1, 32'h00000F00, 0, 8, 4, "R3");
    issue(1, 32'h00000700, 0, 8, 4, "R3");
    // R4 insert keeps outside bits
    issue(2, 32'h0000000A, 32'hFFFFFFFF, 12, 4, "R4");
    issue(2, 32'h12345678, 32'h00000000, 16, 16, "R4");
    idle(1);
    // R5 zero length
    issue(0, 32'hFFFFFFFF, 0, 5, 0, "R5");
    issue(1, 32'hFFFFFFFF, 0, 5, 0, "R5");
    issue(2, 32'hFFFFFFFF, 32'hA5A5A5A5, 5, 0, "R5");
    // R6 clipping, sign from bit 31
    issue(0, 32'hF0000000, 0, 28, 8, "R6");
    issue(1, 32'h80000000, 0, 28, 8, "R6");
    issue(1, 32'h40000000, 0, 30, 63, "R6");
    issue(2, 32'hFFFFFFFF, 32'h00000000, 30, 40, "R6");
    // R7 leading zeros
    issue(3, 32'h00000000, 0, 0, 0, "R7");
    issue(3, 32'hFFFFFFFF, 0, 0, 0, "R7");
    issue(3, 32'h00000001, 0, 0, 0, "R7");
    // R8 population
    issue(4, 32'h00000000, 0, 0, 0, "R8");
    issue(4, 32'hFFFFFFFF, 0, 0, 0, "R8");
    issue(4, 32'hF0F00001, 0, 0, 0, "R8");
    // R1 unused codes
    issue(5, 32'hFFFFFFFF, 32'hFFFFFFFF, 3, 5, "R1");
    issue(6, 32'hFFFFFFFF, 32'hFFFFFFFF, 3, 5, "R1");
    issue(7, 32'hFFFFFFFF, 32'hFFFFFFFF, 3, 5, "R1");
    idle(3);

    // mixed back-to-back stream with gaps (R9)
    for (int n = 0; n < 400; n++) begin
      int op;
      int pos;
      int len;
      op  = int'($urandom_range(0, 7));
      pos = int'($urandom_range(0, 31));
      len = int'($urandom_range(0, 40));
      issue(op, $urandom, $urandom, pos, len, reqFor(op, pos, len));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(3);
    running = 1'b0;
    check(expQ.size() == 0, "R9 all results returned", 32'(expQ.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule